// File: doc/BRIEF.md
# SPI Flash Power-Mode Controller

This block is the slave-side instruction logic of a serial flash memory. It decodes one-byte instructions arriving on a mode-0 serial interface and tracks three power modes: Standby, Active and Deep Power-down. The chip select, serial clock and serial data input are oversampled by the system clock through synchronizers. A busy flag from the internal write, program or erase engine blocks power-down requests and holds the part in Active.

A power-down instruction only takes effect when chip select rises right after its eighth bit and no internal cycle is running. After a fixed entry delay the controller reports Deep Power-down. In that mode it discards every instruction except release/read-signature. That instruction starts a release delay, after which the part returns to normal operation. The same instruction, followed by three dummy bytes, returns a one-byte signature on the serial output. The signature repeats for as long as chip select stays low.

Top module: `spf_pwr_ctrl`

## Requirements
- R1: After reset the mode output reads Standby (2'b00), the accept strobe is low and the serial output enable is low.
- R2: The mode output encodes Standby as 2'b00, Active as 2'b01 and Deep Power-down as 2'b10. Outside Deep Power-down it reads Active while chip select is low, while busy_i is high, or during the entry delay, and Standby otherwise. It never reads 2'b11.
- R3: Instruction bits are captured MSB first on rising serial clock edges while chip select is low. When chip select rises after at least 8 bits, a non-power-down opcode is accepted, with accept_o high for exactly one clock, and the mode stays out of Deep Power-down.
- R4: The power-down opcode 0xB9 is accepted only if chip select rises after exactly 8 bits. With 7 or 9 bits there is no accept and no mode change.
- R5: A 0xB9 frame that ends while busy_i is high is rejected: no accept strobe and no later entry into Deep Power-down.
- R6: After an accepted 0xB9, the mode reads Active, then reads Deep Power-down exactly T_DP clocks after the accept strobe.
- R7: Frames that end during the entry delay are ignored, including 0xAB. The entry still completes on time.
- R8: In Deep Power-down every instruction other than 0xAB is ignored, as is a 0xAB frame shorter than 8 bits: no accept and the mode stays 2'b10.
- R9: A 0xAB frame of at least 8 bits in Deep Power-down is accepted. The mode keeps reading 2'b10 and leaves it exactly T_RES clocks after the accept strobe.
- R10: After 0xAB and DUMMY_BYTES further bytes, the signature SIG is shifted out MSB first, changing after falling serial clock edges, and repeats every 8 bits while chip select is low. sdo_oe_o is high during this output.
- R11: sdo_oe_o is low whenever cs_ni is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock (mode 0) |
| sdi_i | input | 1 | Serial data in |
| busy_i | input | 1 | Internal write/program/erase cycle running |
| pwr_mode_o | output | 2 | Power mode: 00 Standby, 01 Active, 10 Deep Power-down |
| accept_o | output | 1 | One-clock strobe when an instruction is accepted |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (pad is high-impedance when low) |

## Verification
The bench builds the block with T_DP = 300 and T_RES = 200 clocks. These values are long enough that a complete instruction frame fits inside the entry delay, which makes the ignored-during-entry case reachable. They are also short enough to measure both delays to the exact cycle. It keeps DUMMY_BYTES = 3 and a signature of 8'h5C so that the signature comes back twice in a row in one frame. A serial clock of twelve system clocks per bit leaves room for the two-stage synchronizer latency before each sample.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam logic [7:0] OP_PWR_DOWN = 8'hB9;
  localparam logic [7:0] OP_WAKE_SIG = 8'hAB;

  typedef enum logic [1:0] {
    MODE_STBY = 2'b00,
    MODE_ACT  = 2'b01,
    MODE_DPD  = 2'b10
  } pwr_mode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_ENTER,
    ST_DOWN,
    ST_WAKE
  } pwr_st_e;
endpackage

// File: rtl/spf_sync.sv
module spf_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= {STAGES{RST_VAL[g]}};
      else         pipe <= {pipe[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/spf_decoder.sv
module spf_decoder #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          sck_s_i,
  input  logic          sdi_s_i,
  output logic          cs_rise_o,
  output logic          sck_fall_o,
  output logic [CW-1:0] frame_bits_o,
  output logic [7:0]    opcode_o
);
  localparam logic [CW-1:0] BITS_MAX = '1;

  logic       sck_q, cs_q, sck_rise;
  logic [6:0] sr;

  assign sck_rise   = !cs_s_i &&  sck_s_i && !sck_q;
  assign sck_fall_o = !cs_s_i && !sck_s_i &&  sck_q;
  assign cs_rise_o  =  cs_s_i && !cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q        <= 1'b0;
      cs_q         <= 1'b1;
      sr           <= '0;
      frame_bits_o <= '0;
      opcode_o     <= '0;
    end else begin
      sck_q <= sck_s_i;
      cs_q  <= cs_s_i;
      if (cs_s_i) begin
        frame_bits_o <= '0;
      end else if (sck_rise) begin
        sr <= {sr[5:0], sdi_s_i};
        if (frame_bits_o != BITS_MAX) frame_bits_o <= frame_bits_o + 1'b1;
        if (frame_bits_o == CW'(7))   opcode_o     <= {sr, sdi_s_i};
      end
    end
  end
endmodule

// File: rtl/spf_pwr_fsm.sv
module spf_pwr_fsm
  import spf_pkg::*;
#(
  parameter int CW    = 6,
  parameter int T_DP  = 600,
  parameter int T_RES = 600
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          cs_rise_i,
  input  logic          busy_i,
  input  logic [CW-1:0] frame_bits_i,
  input  logic [7:0]    opcode_i,
  output logic [1:0]    mode_o,
  output logic          accept_o,
  output logic          listen_o
);
  localparam int DMAX  = (T_DP > T_RES) ? T_DP : T_RES;
  localparam int DW    = $clog2(DMAX + 1);

  pwr_st_e       state;
  logic [DW-1:0] cnt;
  logic          got_op, full_byte;

  assign got_op    = frame_bits_i >= CW'(8);
  assign full_byte = frame_bits_i == CW'(8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_RUN;
      cnt      <= '0;
      accept_o <= 1'b0;
    end else begin
      accept_o <= 1'b0;
      unique case (state)
        ST_RUN: if (cs_rise_i && got_op) begin
          if (opcode_i != OP_PWR_DOWN) begin
            accept_o <= 1'b1;
          end else if (full_byte && !busy_i) begin
            accept_o <= 1'b1;
            state    <= ST_ENTER;
            cnt      <= DW'(T_DP - 1);
          end
        end
        ST_ENTER: if (cnt == '0) state <= ST_DOWN;
                  else           cnt   <= cnt - 1'b1;
        ST_DOWN: if (cs_rise_i && got_op && opcode_i == OP_WAKE_SIG) begin
          accept_o <= 1'b1;
          state    <= ST_WAKE;
          cnt      <= DW'(T_RES - 1);
        end
        ST_WAKE: if (cnt == '0) state <= ST_RUN;
                 else           cnt   <= cnt - 1'b1;
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    if (state == ST_DOWN || state == ST_WAKE)               mode_o = MODE_DPD;
    else if (state == ST_ENTER || !cs_s_i || busy_i)       mode_o = MODE_ACT;
    else                                                   mode_o = MODE_STBY;
  end

  assign listen_o = (state == ST_RUN) || (state == ST_DOWN);
endmodule

// File: rtl/spf_sig_tx.sv
module spf_sig_tx
  import spf_pkg::*;
#(
  parameter int         CW        = 6,
  parameter int         SIG_START = 32,
  parameter logic [7:0] SIG       = 8'h13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          sck_fall_i,
  input  logic          listen_i,
  input  logic [CW-1:0] frame_bits_i,
  input  logic [7:0]    opcode_i,
  output logic          sdo_o,
  output logic          active_o
);
  logic [7:0] sr;
  logic [2:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr       <= '0;
      cnt      <= '0;
      active_o <= 1'b0;
    end else if (cs_s_i) begin
      cnt      <= '0;
      active_o <= 1'b0;
    end else if (sck_fall_i && listen_i && opcode_i == OP_WAKE_SIG &&
                 frame_bits_i >= CW'(SIG_START)) begin
      if (!active_o || cnt == 3'd7) begin
        sr       <= SIG;
        cnt      <= '0;
        active_o <= 1'b1;
      end else begin
        sr  <= {sr[6:0], 1'b0};
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign sdo_o = sr[7];
endmodule

// File: rtl/spf_pwr_ctrl.sv
module spf_pwr_ctrl #(
  parameter int         T_DP        = 600,
  parameter int         T_RES       = 600,
  parameter int         DUMMY_BYTES = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] SIG         = 8'h13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       sdi_i,
  input  logic       busy_i,
  output logic [1:0] pwr_mode_o,
  output logic       accept_o,
  output logic       sdo_o,
  output logic       sdo_oe_o
);
  localparam int SIG_START = 8 * (1 + DUMMY_BYTES);
  localparam int CW        = $clog2(SIG_START + 2);

  logic          cs_s, sck_s, sdi_s;
  logic          cs_rise, sck_fall, listen, sig_on;
  logic [CW-1:0] frame_bits;
  logic [7:0]    opcode;

  spf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({cs_ni, sck_i, sdi_i}),
    .q_o ({cs_s, sck_s, sdi_s})
  );

  spf_decoder #(.CW(CW)) u_dec (
    .clk_i, .rst_ni,
    .cs_s_i(cs_s), .sck_s_i(sck_s), .sdi_s_i(sdi_s),
    .cs_rise_o(cs_rise), .sck_fall_o(sck_fall),
    .frame_bits_o(frame_bits), .opcode_o(opcode)
  );

  spf_pwr_fsm #(.CW(CW), .T_DP(T_DP), .T_RES(T_RES)) u_fsm (
    .clk_i, .rst_ni,
    .cs_s_i(cs_s), .cs_rise_i(cs_rise), .busy_i,
    .frame_bits_i(frame_bits), .opcode_i(opcode),
    .mode_o(pwr_mode_o), .accept_o, .listen_o(listen)
  );

  spf_sig_tx #(.CW(CW), .SIG_START(SIG_START), .SIG(SIG)) u_sig (
    .clk_i, .rst_ni,
    .cs_s_i(cs_s), .sck_fall_i(sck_fall), .listen_i(listen),
    .frame_bits_i(frame_bits), .opcode_i(opcode),
    .sdo_o, .active_o(sig_on)
  );

  // raw chip select releases the pad without synchronizer latency
  assign sdo_oe_o = sig_on && !cs_ni;
endmodule

// File: rtl/spf_pwr_ctrl_chk.sv
module spf_pwr_ctrl_chk #(
  parameter int T_DP  = 600,
  parameter int T_RES = 600
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic [1:0] pwr_mode_o,
  input logic       accept_o,
  input logic       sdo_oe_o
);
  localparam int DMAX = (T_DP > T_RES) ? T_DP : T_RES;
  localparam int GW   = $clog2(DMAX + 2);
  localparam logic [GW-1:0] GMAX = '1;

  logic [GW-1:0] gap;
  logic          dpd;

  assign dpd = pwr_mode_o == 2'b10;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap <= GMAX;
    else if (accept_o)    gap <= GW'(1);
    else if (gap != GMAX) gap <= gap + 1'b1;
  end

  a_r2_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_mode_o != 2'b11);
  a_r6_entry_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dpd) |-> gap == GW'(T_DP));
  a_r6_entry_from_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dpd) |-> $past(pwr_mode_o) == 2'b01);
  a_r9_release_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dpd) |-> gap == GW'(T_RES));
  a_r3_accept_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);
  a_r11_sdo_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !sdo_oe_o);
endmodule

bind spf_pwr_ctrl spf_pwr_ctrl_chk #(.T_DP(T_DP), .T_RES(T_RES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni),
  .pwr_mode_o(pwr_mode_o), .accept_o(accept_o), .sdo_oe_o(sdo_oe_o)
);

// File: tb/spf_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module spf_pwr_ctrl_bench;
  localparam int         T_DP  = 300;
  localparam int         T_RES = 200;
  localparam logic [7:0] SIG   = 8'h5C;
  localparam int         H     = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, busy = 1'b0;
  logic [1:0] mode;
  logic acc, sdo, sdo_oe;

  int checks = 0, errors = 0;
  int cyc = 0, acc_n = 0, acc_cyc = 0, rise_cyc = 0, fall_cyc = 0;
  logic [1:0] prev_mode = 2'b00;
  bit done = 0;

  always #2.5 clk = ~clk;

  spf_pwr_ctrl #(.T_DP(T_DP), .T_RES(T_RES), .DUMMY_BYTES(3),
                 .SYNC_STAGES(2), .SIG(SIG)) u_spf_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .busy_i(busy), .pwr_mode_o(mode), .accept_o(acc), .sdo_o(sdo),
    .sdo_oe_o(sdo_oe)
  );

  always @(negedge clk) begin
    cyc++;
    if (acc) begin acc_n++; acc_cyc = cyc; end
    if (mode == 2'b10 && prev_mode != 2'b10) rise_cyc = cyc;
    if (mode != 2'b10 && prev_mode == 2'b10) fall_cyc = cyc;
    prev_mode = mode;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdi = b[i]; wclk(H); sck = 1'b1; wclk(H); sck = 1'b0;
    end
  endtask

  task automatic read_byte(output logic [7:0] v, output int oe_ok);
    oe_ok = 1;
    for (int i = 7; i >= 0; i--) begin
      wclk(H); v[i] = sdo; if (!sdo_oe) oe_ok = 0;
      sck = 1'b1; wclk(H); sck = 1'b0;
    end
  endtask

  task automatic frame(logic [7:0] op, int n);
    cs_n = 1'b0; wclk(H);
    send_bits(op, n);
    wclk(H); cs_n = 1'b1; wclk(10);
  endtask

  task automatic t_reset;
    chk("R1 mode", mode, 0);
    chk("R1 accept", acc, 0);
    chk("R1 sdo_oe", sdo_oe, 0);
    cs_n = 1'b0; wclk(6);
    chk("R2 cs low active", mode, 1);
    cs_n = 1'b1; busy = 1'b1; wclk(6);
    chk("R2 busy active", mode, 1);
    busy = 1'b0; wclk(6);
    chk("R2 standby", mode, 0);
  endtask

  task automatic t_plain;
    int a0 = acc_n;
    frame(8'h06, 8);
    chk("R3 plain accepted", acc_n - a0, 1);
    chk("R3 plain mode", mode, 0);
    frame(8'h03, 8); send_bits(8'h00, 0);
    chk("R3 second accepted", acc_n - a0, 2);
  endtask

  task automatic t_bad_count;
    int a0 = acc_n;
    frame(8'hB9, 7);
    chk("R4 7 bits no accept", acc_n - a0, 0);
    cs_n = 1'b0; wclk(H); send_bits(8'hB9, 8); send_bits(8'h80, 1);
    wclk(H); cs_n = 1'b1; wclk(10);
    chk("R4 9 bits no accept", acc_n - a0, 0);
    wclk(T_DP + 20);
    chk("R4 mode standby", mode, 0);
  endtask

  task automatic t_busy;
    int a0 = acc_n;
    busy = 1'b1;
    frame(8'hB9, 8);
    chk("R5 busy no accept", acc_n - a0, 0);
    chk("R5 busy active", mode, 1);
    busy = 1'b0; wclk(T_DP + 20);
    chk("R5 no power-down", mode, 0);
  endtask

  task automatic t_signature;
    logic [7:0] v; int ok; int a0 = acc_n;
    cs_n = 1'b0; wclk(H);
    send_bits(8'hAB, 8);
    for (int k = 0; k < 3; k++) send_bits(8'h00, 8);
    read_byte(v, ok);
    chk("R10 signature byte 0", v, SIG);
    chk("R10 oe during output", ok, 1);
    read_byte(v, ok);
    chk("R10 signature repeat", v, SIG);
    wclk(H); cs_n = 1'b1; #1;
    chk("R11 oe off at cs high", sdo_oe, 0);
    wclk(10);
    chk("R3 release op accepted", acc_n - a0, 1);
    chk("R3 still standby", mode, 0);
  endtask

  task automatic t_enter;
    int a0;
    frame(8'hB9, 8);
    chk("R6 dp accepted", acc_n >= 1, 1);
    a0 = acc_n;
    chk("R6 active during delay", mode, 1);
    frame(8'hAB, 8);
    chk("R7 ignored during entry", acc_n - a0, 0);
    chk("R7 still entering", mode, 1);
    wclk(T_DP + 20);
    chk("R6 deep power-down", mode, 2);
    chk("R6 entry delay", rise_cyc - acc_cyc, T_DP);
  endtask

  task automatic t_ignore;
    int a0 = acc_n;
    frame(8'h06, 8);
    frame(8'h02, 8);
    frame(8'hD8, 8);
    frame(8'hB9, 8);
    frame(8'hAB, 7);
    chk("R8 no accept in dpd", acc_n - a0, 0);
    chk("R8 mode stays dpd", mode, 2);
  endtask

  task automatic t_release;
    logic [7:0] v; int ok; int a0 = acc_n;
    cs_n = 1'b0; wclk(H);
    send_bits(8'hAB, 8);
    for (int k = 0; k < 3; k++) send_bits(8'hFF, 8);
    read_byte(v, ok);
    chk("R10 signature in dpd", v, SIG);
    wclk(H); cs_n = 1'b1; wclk(10);
    chk("R9 release accepted", acc_n - a0, 1);
    chk("R9 dpd during release", mode, 2);
    wclk(T_RES + 20);
    chk("R9 back to standby", mode, 0);
    chk("R9 release delay", fall_cyc - acc_cyc, T_RES);
  endtask

  initial begin
    wclk(4); rst_n = 1'b1; wclk(4);
    t_reset();
    t_plain();
    t_bad_count();
    t_busy();
    t_signature();
    t_enter();
    t_ignore();
    t_release();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule